// File: doc/BRIEF.md
# Per-Port Busy Time Monitor

This block measures how long each downstream port of a hub is held busy. A port becomes busy in the cycle a trigger is sent to it and stays busy until its reply has come back. For every port the block keeps two saturating counters that advance on a time-base tick, for example one pulse per microsecond. The inclusive counter advances whenever its port is busy. The exclusive counter advances only while its port is the single busy port, which shows the time one port alone is holding up the system.

A free-running global time counter advances on the same tick. Software reads the counters and the global time over a small register bus, so it can relate the counts to a point in time. A write to the first address of either counter bank clears that whole bank at once.

Top module: `busy_time_monitor`

## Requirements
- R1: A trigger pulse on a port makes it busy from the next cycle on. A reply pulse makes it idle from the next cycle on. If both pulses come in the same cycle, the port is busy afterwards.
- R2: The inclusive counter of port p is read at offset 0x30+p. It increments on every tick in which port p is busy, whatever the other ports are doing.
- R3: The exclusive counter of port p is read at offset 0x40+p. It increments on a tick only when port p is busy and every other port is idle.
- R4: Every counter and the global time stop at all ones instead of wrapping.
- R5: A write to offset 0x30 clears all inclusive counters and leaves the exclusive counters as they are. The clear wins over a tick in the same cycle.
- R6: A write to offset 0x40 clears all exclusive counters and leaves the inclusive counters as they are.
- R7: A write to any other offset changes no counter and no global time value.
- R8: The global time is read at offset 0x50. It increments by one on every tick and no bus write clears it.
- R9: For a read of a mapped offset, the read data and a high `bus_ack` appear in the cycle after the read strobe. The data are the counter value before that cycle's tick, zero-extended to the bus width.
- R10: For a read of any other offset, `bus_rdata` is zero and `bus_unknown` is high in the cycle after the strobe, and `bus_ack` stays low.
- R11: After reset all counters, busy flags and bus outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base pulse; counters advance on it |
| trig_sent | input | NPORTS | Per-port pulse: a trigger was sent |
| reply_rcvd | input | NPORTS | Per-port pulse: a reply was received |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data (value not used) |
| bus_rdata | output | DATA_W | Registered read data |
| bus_ack | output | 1 | Read of a mapped offset done |
| bus_unknown | output | 1 | Read of an unmapped offset |

## Verification
Two events can fall in the same cycle here. A bank-clear write can arrive with a tick, and a trigger and a reply can arrive together on one port. The bench drives the clear write to offset 0x30 in the same cycle as a tick pulse, while the exclusive counters hold nonzero values. It also drives trigger and reply together on one busy port and one idle port. A reference model built from the requirements predicts every read, and a scoreboard compares the predictions with the results. The clear must leave the inclusive bank at zero and the exclusive bank unchanged. After the same-cycle trigger and reply, both ports must count as busy, which the exclusive counts make visible at the bus.

// File: rtl/busy_time_monitor.sv
module busy_time_monitor #(
  parameter int NPORTS = 16,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NPORTS-1:0] trig_sent,
  input  logic [NPORTS-1:0] reply_rcvd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              bus_unknown
);
  localparam int IDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1;
  localparam int INC_BASE = 'h30;
  localparam int EXC_BASE = 'h40;
  localparam int TIME_ADR = 'h50;
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [NPORTS-1:0] busy_q;
  logic [CNT_W-1:0]  inc_q [NPORTS];
  logic [CNT_W-1:0]  exc_q [NPORTS];
  logic [CNT_W-1:0]  gtime_q;
  logic [DATA_W-1:0] rd_val;
  logic              rd_hit;

  wire clr_inc = bus_wr && (int'(bus_addr) == INC_BASE);
  wire clr_exc = bus_wr && (int'(bus_addr) == EXC_BASE);
  wire unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= (busy_q & ~reply_rcvd) | trig_sent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       gtime_q <= '0;
    else if (tick && gtime_q != CMAX) gtime_q <= gtime_q + CNT_W'(1);
  end

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    wire alone = (busy_q == (NPORTS'(1) << p));
    always_ff @(posedge clk) begin
      if (!rst_n || clr_inc)                          inc_q[p] <= '0;
      else if (tick && busy_q[p] && inc_q[p] != CMAX) inc_q[p] <= inc_q[p] + CNT_W'(1);
    end
    always_ff @(posedge clk) begin
      if (!rst_n || clr_exc)                     exc_q[p] <= '0;
      else if (tick && alone && exc_q[p] != CMAX) exc_q[p] <= exc_q[p] + CNT_W'(1);
    end
  end

  always_comb begin
    int a;
    a = int'(bus_addr);
    rd_hit = 1'b1;
    rd_val = '0;
    if (a >= INC_BASE && a < INC_BASE + NPORTS)
      rd_val = DATA_W'(inc_q[IDX_W'(a - INC_BASE)]);
    else if (a >= EXC_BASE && a < EXC_BASE + NPORTS)
      rd_val = DATA_W'(exc_q[IDX_W'(a - EXC_BASE)]);
    else if (a == TIME_ADR)
      rd_val = DATA_W'(gtime_q);
    else
      rd_hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata   <= '0;
      bus_ack     <= 1'b0;
      bus_unknown <= 1'b0;
    end else begin
      bus_rdata   <= (bus_rd && rd_hit) ? rd_val : '0;
      bus_ack     <= bus_rd && rd_hit;
      bus_unknown <= bus_rd && !rd_hit;
    end
  end
endmodule

// File: rtl/busy_time_monitor_chk.sv
module busy_time_monitor_chk #(
  parameter int NPORTS = 16,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_rd,
  input logic              bus_ack,
  input logic              bus_unknown,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NPORTS-1:0] trig,
  input logic [NPORTS-1:0] reply,
  input logic [NPORTS-1:0] busy,
  input logic [CNT_W-1:0]  gtime
);
  // R10
  ack_unk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bus_ack && bus_unknown));
  // R10
  unk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_unknown |-> bus_rdata == '0);
  // R9
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) bus_rd |=> (bus_ack || bus_unknown));
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> !bus_ack && !bus_unknown);
  // R8
  gtime_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(gtime));
  // R8
  gtime_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && gtime != '1) |=> gtime == $past(gtime) + CNT_W'(1));
  // R1
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |=> (busy & $past(trig)) == $past(trig));
  // R1
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reply != '0) |=> (busy & $past(reply & ~trig)) == '0);
endmodule

bind busy_time_monitor busy_time_monitor_chk #(.NPORTS(NPORTS), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_rd(bus_rd), .bus_ack(bus_ack),
  .bus_unknown(bus_unknown), .bus_rdata(bus_rdata), .trig(trig_sent),
  .reply(reply_rcvd), .busy(busy_q), .gtime(gtime_q)
);

// File: tb/sim_busy_time_monitor.sv
module sim_busy_time_monitor;
  localparam int PERIOD = 10;
  localparam int NP = 16;
  localparam int CW = 8;

  logic clk = 0, rst_n = 0, tick = 0, bus_rd = 0, bus_wr = 0;
  logic [NP-1:0] trig = '0, reply = '0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_ack, bus_unknown;
  int checks = 0, fails = 0;

  typedef struct { logic [31:0] d; logic ack; logic unk; int req; logic [7:0] a; } exp_t;
  exp_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  busy_time_monitor #(.NPORTS(NP), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_sent(trig), .reply_rcvd(reply),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_unknown(bus_unknown));

  // Reference model from the requirements
  logic [NP-1:0] m_busy;
  logic [CW-1:0] m_inc [NP];
  logic [CW-1:0] m_exc [NP];
  logic [CW-1:0] m_time;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= '0; m_time <= '0;
      for (int p = 0; p < NP; p++) begin m_inc[p] <= '0; m_exc[p] <= '0; end
    end else begin
      m_busy <= (m_busy & ~reply) | trig;                          // R1
      if (tick && m_time != '1) m_time <= m_time + 1'b1;           // R8, R4
      for (int p = 0; p < NP; p++) begin
        if (bus_wr && bus_addr == 8'h30) m_inc[p] <= '0;           // R5
        else if (tick && m_busy[p] && m_inc[p] != '1) m_inc[p] <= m_inc[p] + 1'b1; // R2
        if (bus_wr && bus_addr == 8'h40) m_exc[p] <= '0;           // R6
        else if (tick && m_busy == (NP'(1) << p) && m_exc[p] != '1) m_exc[p] <= m_exc[p] + 1'b1; // R3
      end
    end
  end

  task automatic check(input bit ok, input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: issues a read and pushes the expected response
  task automatic rd(input logic [7:0] a, input int req);
    exp_t e;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    e.a = a; e.req = req; e.ack = 1; e.unk = 0;
    if (a >= 8'h30 && a < 8'h40) e.d = 32'(m_inc[a[3:0]]);
    else if (a >= 8'h40 && a < 8'h50) e.d = 32'(m_exc[a[3:0]]);
    else if (a == 8'h50) e.d = 32'(m_time);
    else begin e.d = 0; e.ack = 0; e.unk = 1; end
    sb.push_back(e);
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic [7:0] a, input bit with_tick);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = 32'hDEAD_BEEF; tick = with_tick;
    @(negedge clk);
    bus_wr = 0; tick = 0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic pulse(input logic [NP-1:0] t, input logic [NP-1:0] r);
    @(negedge clk); trig = t; reply = r;
    @(negedge clk); trig = '0; reply = '0;
  endtask

  task automatic read_all(input int req);
    for (int p = 0; p < NP; p++) rd(8'h30 + 8'(p), req);
    for (int p = 0; p < NP; p++) rd(8'h40 + 8'(p), req);
    rd(8'h50, 8);
  endtask

  // Monitor: compares results one cycle after each read strobe (R9, R10)
  logic rd_seen = 0;
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(bus_rdata == e.d, e.req, bus_rdata, e.d);
      check(bus_ack == e.ack, 9, 32'(bus_ack), 32'(e.ack));
      check(bus_unknown == e.unk, 10, 32'(bus_unknown), 32'(e.unk));
    end
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state at the outputs
    check(bus_rdata == 0 && !bus_ack && !bus_unknown, 11, bus_rdata, 0);
    rst_n = 1;
    read_all(11);
    // R2 R3 one port alone
    pulse(NP'(1) << 3, '0);
    ticks(5);
    read_all(3);
    // R2 two ports busy: exclusive halts
    pulse(NP'(1) << 7, '0);
    ticks(4);
    read_all(2);
    // R1 reply on port 3 leaves port 7 alone
    pulse('0, NP'(1) << 3);
    ticks(3);
    read_all(3);
    // R1 trigger and reply together on busy port 7 and idle port 9
    pulse((NP'(1) << 7) | (NP'(1) << 9), (NP'(1) << 7) | (NP'(1) << 9));
    ticks(2);
    read_all(1);
    // R7 writes elsewhere are ignored
    wr(8'h31, 0); wr(8'h45, 0); wr(8'h50, 0);
    read_all(7);
    // R5 clear inclusive bank together with a tick
    wr(8'h30, 1);
    read_all(5);
    ticks(2);
    // R6 clear exclusive bank
    wr(8'h40, 0);
    read_all(6);
    // R10 unmapped offsets
    rd(8'h00, 10); rd(8'h2F, 10); rd(8'h51, 10); rd(8'hFF, 10);
    // R4 saturation with port 0 alone
    pulse(NP'(1), (NP'(1) << 7) | (NP'(1) << 9));
    ticks(300);
    rd(8'h30, 4); rd(8'h40, 4); rd(8'h50, 4);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule